// File: doc/BRIEF.md
# Grouped PWM LED Brightness Driver

This block dims nine LED enables under firmware control while keeping peak supply current bounded. Each channel holds a 4-bit brightness level. A perceptual curve turns the level into an on-time measured in slots, out of 64 slots per phase. The nine channels are split into three fixed groups. A PWM frame has three equal phases, and during each phase only one group may be lit. As a result, no more than three enables are ever high together.

Software writes levels through a single-cycle parallel write port. The block holds each written level as pending and copies all pending levels into the active set in one step at a frame boundary. A level change therefore never cuts or stretches a pulse that is already under way. Frame pacing comes from an external tick enable. A 4 MHz clock with a tick about every 18 cycles gives the intended refresh of roughly 1.1 kHz for a 192-tick frame.

Top module: `led_trio_pwm`

## Requirements
- R1: While rst_n is low, and after it is released until a frame boundary has loaded non-zero levels, every bit of led is 0. The slot and phase counters start at 0.
- R2: Brightness level L (0..15) maps to an on-time of D(L) slots, with D = 0,1,2,3,5,7,9,12,15,19,24,30,37,45,54,64 for L = 0..15. The mid level 8 gives 15.
- R3: In every clock cycle, at most three bits of led are 1.
- R4: Channel c belongs to group c/3 (0..2, 3..5, 6..8). A channel can be lit only while the phase equals its group. Each phase lasts 64 ticks, and the phases run 0, 1, 2, then back to 0.
- R5: The 6-bit slot counter advances by one on every tick and wraps from 63 to 0. Inside its own phase, a channel is on exactly while slot < D(active level).
- R6: A write stores the level as pending. The whole pending set becomes active only at the edge where a tick arrives with slot 63 in phase 2. A write made in the middle of a frame leaves the current frame unchanged.
- R7: A write whose wr_addr is 9 or higher changes no level.
- R8: Level 15 keeps a channel on for all 64 slots of its phase. Level 0 keeps it off for the whole frame.
- R9: In a cycle without tick, the slot and phase counters hold their values and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Advances the slot counter by one |
| wr_en | input | 1 | Level write strobe |
| wr_addr | input | 4 | Channel index of the write |
| wr_level | input | 4 | Brightness level to store |
| led | output | 9 | Active-high LED enables, bit c is channel c |

## Verification
The bench counts the lit ticks of every channel across whole frames and compares each count with the curve value. An off-by-one compare (<= instead of <) would give one extra slot for each channel. A mapping error would give a wrong count for the level concerned. A write landed in the middle of a frame is timed so that a design which forwards levels directly would change that frame's count for channel 4. Frames with sparse ticks would reveal counters that advance without a tick. Writes to addresses 9 to 15, and a frame with every channel at full level, target a write decoder that aliases onto a real channel and a group gate that lets a fourth output through.

// File: rtl/ledpwm_pkg.sv
`timescale 1ns/1ps
package ledpwm_pkg;
  parameter int LVL_W  = 4;
  parameter int SLOT_W = 6;
  localparam int DUTY_W = SLOT_W + 1;

  // perceptual curve: level -> lit slots out of 2**SLOT_W
  function automatic logic [DUTY_W-1:0] duty_of(input logic [LVL_W-1:0] lvl);
    logic [DUTY_W-1:0] d;
    case (lvl)
      4'd0:  d = 7'd0;
      4'd1:  d = 7'd1;
      4'd2:  d = 7'd2;
      4'd3:  d = 7'd3;
      4'd4:  d = 7'd5;
      4'd5:  d = 7'd7;
      4'd6:  d = 7'd9;
      4'd7:  d = 7'd12;
      4'd8:  d = 7'd15;
      4'd9:  d = 7'd19;
      4'd10: d = 7'd24;
      4'd11: d = 7'd30;
      4'd12: d = 7'd37;
      4'd13: d = 7'd45;
      4'd14: d = 7'd54;
      default: d = 7'd64;
    endcase
    return d;
  endfunction

  function automatic logic slot_lit(input logic [SLOT_W-1:0] slot,
                                    input logic [DUTY_W-1:0] duty);
    return ({1'b0, slot} < duty);
  endfunction
endpackage

// File: rtl/ledpwm_frame_timer.sv
`timescale 1ns/1ps
module ledpwm_frame_timer #(
  parameter int NUM_GRP = 3,
  parameter int SLOT_W  = 6,
  parameter int PH_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [SLOT_W-1:0] slot_q,
  output logic [PH_W-1:0]   phase_q,
  output logic              frame_wrap
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NUM_GRP - 1);

  logic slot_last;
  logic phase_last;

  assign slot_last  = &slot_q;
  assign phase_last = (phase_q == PH_LAST);
  assign frame_wrap = tick && slot_last && phase_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      phase_q <= '0;
    end else if (tick) begin
      slot_q <= slot_q + 1'b1;
      if (slot_last) begin
        phase_q <= phase_last ? '0 : phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ledpwm_level_bank.sv
`timescale 1ns/1ps
module ledpwm_level_bank #(
  parameter int NUM_CH = 9,
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [LVL_W-1:0]             wr_level,
  input  logic                         frame_wrap,
  output logic [NUM_CH-1:0][LVL_W-1:0] pend_q,
  output logic [NUM_CH-1:0][LVL_W-1:0] act_q
);
  logic wr_ok;

  assign wr_ok = wr_en && (int'(wr_addr) < NUM_CH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (frame_wrap) begin
        act_q <= pend_q;
      end
      if (wr_ok) begin
        pend_q[wr_addr] <= wr_level;
      end
    end
  end
endmodule

// File: rtl/ledpwm_group_gate.sv
`timescale 1ns/1ps
module ledpwm_group_gate #(
  parameter int NUM_CH   = 9,
  parameter int GROUP_SZ = 3,
  parameter int PH_W     = 2
) (
  input  logic [ledpwm_pkg::SLOT_W-1:0]                slot_q,
  input  logic [PH_W-1:0]                              phase_q,
  input  logic [NUM_CH-1:0][ledpwm_pkg::LVL_W-1:0]     act_q,
  output logic [NUM_CH-1:0]                            led
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [PH_W-1:0] OWNER = PH_W'(ch / GROUP_SZ);
    logic [ledpwm_pkg::DUTY_W-1:0] duty;
    assign duty    = ledpwm_pkg::duty_of(act_q[ch]);
    assign led[ch] = (phase_q == OWNER) && ledpwm_pkg::slot_lit(slot_q, duty);
  end
endmodule

// File: rtl/led_trio_pwm.sv
`timescale 1ns/1ps
module led_trio_pwm #(
  parameter int NUM_CH   = 9,
  parameter int GROUP_SZ = 3,
  parameter int ADDR_W   = $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [ledpwm_pkg::LVL_W-1:0]  wr_level,
  output logic [NUM_CH-1:0]             led
);
  localparam int NUM_GRP = NUM_CH / GROUP_SZ;
  localparam int PH_W    = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int LVL_W   = ledpwm_pkg::LVL_W;
  localparam int SLOT_W  = ledpwm_pkg::SLOT_W;

  logic [SLOT_W-1:0]             slot_q;
  logic [PH_W-1:0]               phase_q;
  logic                          frame_wrap;
  logic [NUM_CH-1:0][LVL_W-1:0]  pend_lvl;
  logic [NUM_CH-1:0][LVL_W-1:0]  act_lvl;

  ledpwm_frame_timer #(.NUM_GRP(NUM_GRP), .SLOT_W(SLOT_W), .PH_W(PH_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .slot_q(slot_q), .phase_q(phase_q), .frame_wrap(frame_wrap)
  );

  ledpwm_level_bank #(.NUM_CH(NUM_CH), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_level(wr_level), .frame_wrap(frame_wrap),
    .pend_q(pend_lvl), .act_q(act_lvl)
  );

  ledpwm_group_gate #(.NUM_CH(NUM_CH), .GROUP_SZ(GROUP_SZ), .PH_W(PH_W)) u_gate (
    .slot_q(slot_q), .phase_q(phase_q), .act_q(act_lvl), .led(led)
  );
endmodule

// File: rtl/ledpwm_chk.sv
`timescale 1ns/1ps
module ledpwm_chk #(
  parameter int NUM_CH   = 9,
  parameter int GROUP_SZ = 3,
  parameter int ADDR_W   = 4,
  parameter int PH_W     = 2
) (
  input logic                                      clk,
  input logic                                      rst_n,
  input logic                                      tick,
  input logic                                      wr_en,
  input logic [ADDR_W-1:0]                         wr_addr,
  input logic [NUM_CH-1:0]                         led,
  input logic [ledpwm_pkg::SLOT_W-1:0]             slot_q,
  input logic [PH_W-1:0]                           phase_q,
  input logic                                      frame_wrap,
  input logic [NUM_CH-1:0][ledpwm_pkg::LVL_W-1:0]  act_lvl,
  input logic [NUM_CH-1:0][ledpwm_pkg::LVL_W-1:0]  pend_lvl
);
  localparam int SLOT_W = ledpwm_pkg::SLOT_W;

  // R3
  three_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(led) <= GROUP_SZ);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(slot_q) && $stable(phase_q)));

  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (slot_q == SLOT_W'($past(slot_q) + 1'b1)));

  // R4
  phase_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&slot_q)) |=> (phase_q != $past(phase_q)));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(act_lvl));

  // R6
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (act_lvl == $past(pend_lvl)));

  // R7
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) >= NUM_CH)) |=> $stable(pend_lvl));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [PH_W-1:0] OWNER = PH_W'(ch / GROUP_SZ);
    // R4
    group_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      led[ch] |-> (phase_q == OWNER));
    // R8
    full_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((&act_lvl[ch]) && (phase_q == OWNER)) |-> led[ch]);
    // R8
    zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_lvl[ch] == '0) |-> !led[ch]);
  end
endmodule

bind led_trio_pwm ledpwm_chk #(
  .NUM_CH(NUM_CH), .GROUP_SZ(GROUP_SZ), .ADDR_W(ADDR_W), .PH_W(PH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .led(led), .slot_q(slot_q), .phase_q(phase_q), .frame_wrap(frame_wrap),
  .act_lvl(act_lvl), .pend_lvl(pend_lvl)
);

// File: tb/sim_led_trio_pwm.sv
`timescale 1ns/1ps
module sim_led_trio_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [3:0] wr_level = '0;
  logic [8:0] led;

  led_trio_pwm u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_level(wr_level), .led(led)
  );

  always #4 clk = ~clk;

  // on-time curve stated in R2
  int lut [16] = '{0, 1, 2, 3, 5, 7, 9, 12, 15, 19, 24, 30, 37, 45, 54, 64};

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_slot = 0;
  int m_phase = 0;
  int m_pend [9];
  int m_act  [9];
  bit cnt_on = 0;
  int cnt [9];

  logic [8:0] sbq [$];

  function automatic logic [8:0] model_led();
    logic [8:0] v;
    for (int c = 0; c < 9; c++)
      v[c] = (m_phase == c / 3) && (m_slot < lut[m_act[c]]);
    return v;
  endfunction

  // monitor: pops expected vectors and compares
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && !done) begin
        checks++;
        if ($countones(led) > 3) begin
          errors++;
          $display("FAIL R3: %0d outputs lit, expected at most 3", $countones(led));
        end
        if (sbq.size() > 0) begin
          logic [8:0] e;
          e = sbq.pop_front();
          checks++;
          if (led !== e) begin
            errors++;
            $display("FAIL %s: led=%b expected %b", cur_req, led, e);
          end
        end
      end
    end
  end

  // driver: one clock of stimulus, model update, push expectation
  task automatic step(input logic t, input logic we, input logic [3:0] a, input logic [3:0] l);
    if (t && cnt_on)
      for (int c = 0; c < 9; c++) if (led[c]) cnt[c]++;
    tick = t; wr_en = we; wr_addr = a; wr_level = l;
    @(posedge clk);
    if (t) begin
      if (m_slot == 63 && m_phase == 2)
        for (int c = 0; c < 9; c++) m_act[c] = m_pend[c];
      if (m_slot == 63) m_phase = (m_phase + 1) % 3;
      m_slot = (m_slot + 1) % 64;
    end
    if (we && a < 9) m_pend[a] = int'(l);
    #1;
    sbq.push_back(model_led());
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic finish_frame(input int gap);
    do begin
      step(1'b1, 1'b0, 4'd0, 4'd0);
      repeat (gap) step(1'b0, 1'b0, 4'd0, 4'd0);
    end while (!(m_slot == 0 && m_phase == 0));
  endtask

  task automatic start_count();
    for (int c = 0; c < 9; c++) cnt[c] = 0;
    cnt_on = 1;
  endtask

  task automatic check_counts(input string tag, input int lv [9]);
    cnt_on = 0;
    for (int c = 0; c < 9; c++) begin
      checks++;
      if (cnt[c] != lut[lv[c]]) begin
        errors++;
        $display("FAIL %s: channel %0d lit %0d ticks, expected %0d", tag, c, cnt[c], lut[lv[c]]);
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int zeros [9] = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
    int lv_a  [9] = '{8, 0, 15, 3, 12, 1, 15, 7, 4};
    int lv_b  [9] = '{8, 0, 15, 3, 15, 1, 15, 7, 4};
    int lv_f  [9] = '{15, 15, 15, 15, 15, 15, 15, 15, 15};
    for (int c = 0; c < 9; c++) begin m_pend[c] = 0; m_act[c] = 0; end

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: outputs dark after reset
    checks++;
    if (led !== 9'b0) begin
      errors++;
      $display("FAIL R1: led=%b expected %b", led, 9'b0);
    end
    @(negedge clk);

    cur_req = "R9 idle cycles";
    repeat (5) step(1'b0, 1'b0, 4'd0, 4'd0);

    // frame 0: writes land in pending only, frame stays dark
    cur_req = "R6 first frame dark";
    start_count();
    for (int c = 0; c < 9; c++) step(1'b1, 1'b1, 4'(c), 4'(lv_a[c]));
    finish_frame(0);
    check_counts("R1/R6 dark until boundary", zeros);

    // frame 1: curve and compare
    cur_req = "R2/R4/R5";
    start_count();
    finish_frame(0);
    check_counts("R2/R5/R8 on-time per level", lv_a);

    // frame 2: mid-frame write of channel 4 inside its own phase
    cur_req = "R6 mid-frame write";
    start_count();
    repeat (100) step(1'b1, 1'b0, 4'd0, 4'd0);
    step(1'b1, 1'b1, 4'd4, 4'd15);
    finish_frame(0);
    check_counts("R6 current frame unchanged", lv_a);

    // frame 3: sparse ticks, new level now active
    cur_req = "R9 sparse ticks";
    start_count();
    finish_frame(2);
    check_counts("R9/R6 sparse frame counts", lv_b);

    // frame 4: writes to unused addresses
    cur_req = "R7 bad address";
    start_count();
    for (int a = 9; a < 16; a++) step(1'b1, 1'b1, 4'(a), 4'd15);
    finish_frame(0);
    check_counts("R7 frame during bad writes", lv_b);
    start_count();
    finish_frame(0);
    check_counts("R7 no level changed", lv_b);

    // frame 6: every channel at full level
    cur_req = "R3/R8 full load";
    start_count();
    for (int c = 0; c < 9; c++) step(1'b1, 1'b1, 4'(c), 4'd15);
    finish_frame(0);
    check_counts("R6 before full load", lv_b);
    start_count();
    finish_frame(0);
    check_counts("R3/R8 full level 64 ticks", lv_f);

    repeat (3) step(1'b0, 1'b0, 4'd0, 4'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule